// File: doc/BRIEF.md
# Serial 4:2:2 Video Timing Tracker

This block watches an 8-bit byte stream that carries interleaved luma and chroma samples with embedded timing reference codes, as defined for CCIR-656 digital video. It finds each four-byte reference code and decodes its field, vertical-blanking and end/start-of-active flags. From these it tracks where the stream is within the line and within the field. It then separates the active bytes into Y, Cb and Cr samples, and pairs each luma sample with its co-sited chroma.

Two field formats are supported: 288 active lines per field (625-line systems, 50 fields/s) and 243 active lines per field (525-line systems, 60 fields/s). The active line width is a parameter and defaults to 720 pixels. A programmable window of active lines gates the sample output. The window end is clamped to the last active line of the selected format. A reference code whose protection bits are inconsistent raises a sticky error flag. In master mode the block drives a field-1 indicator. In slave mode that pin is released, and an external field-1 input tags the samples instead.

Top module: `vid656_tracker`

## Requirements
- R1: A reference code is the byte sequence 0xFF, 0x00, 0x00, XY. In XY, bit 7 must be 1, bit 6 is F, bit 5 is V and bit 4 is H. Bits 3..0 must equal {V^H, F^H, F^V, F^V^H}. H=0 marks start of active video and H=1 marks end of active video.
- R2: A reference code that fails the R1 checks sets `ccir_err`. The flag stays set until reset. The failed code has no other effect: field, line count and active state stay unchanged.
- R3: Active bytes arrive in the order Cb, Y, Cr, Y. One cycle after the Cr byte, `pix_valid` is 1 with the first Y and the pair. One cycle after the second Y byte, `pix_valid` is 1 with that Y and the same pair. Chroma bytes are passed on unchanged as unsigned values centred on 128.
- R4: The active region opens on a valid start code with V=0. It closes on the next valid code, or after 2*ACT_PIX bytes, whichever comes first. Bytes after it are not sampled.
- R5: A valid code with V=1 resets the active-line count to 0. A valid end code with V=0 advances it by one. Samples are emitted only on lines whose count lies within `vwin_start`..`vwin_end`, both ends included, and `vact` is high during such a line.
- R6: If `vwin_end` exceeds the last active line of the selected format, that last line is used instead: 287 when `mode_625`=1, and 242 when `mode_625`=0.
- R7: In master mode (`master`=1), `field_oe` is 1. `field_out` is 1 after a valid code with F=0 (field 1) and 0 after a valid code with F=1.
- R8: In slave mode, `field_oe` and `field_out` are 0, and `pix_field1` carries the level of `field_in` at the byte that produced the sample.
- R9: After reset, `ccir_err`, `pix_valid`, `hact`, `vact` and `field_out` are 0.
- R10: A valid start code with V=1 does not open the active region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vid_byte | input | 8 | Multiplexed video byte |
| mode_625 | input | 1 | 1: 288-line field format, 0: 243-line field format |
| master | input | 1 | 1: drive the field indicator, 0: take it from `field_in` |
| field_in | input | 1 | Field-1 indicator in slave mode |
| vwin_start | input | 10 | First active line of the window |
| vwin_end | input | 10 | Last active line of the window (clamped) |
| field_out | output | 1 | Field-1 indicator driven in master mode |
| field_oe | output | 1 | Output enable for `field_out` |
| hact | output | 1 | Active-byte region of the current line |
| vact | output | 1 | Current line lies in the vertical window |
| pix_valid | output | 1 | Sample strobe |
| pix_y | output | 8 | Luma sample |
| pix_cb | output | 8 | Co-sited blue-difference sample |
| pix_cr | output | 8 | Co-sited red-difference sample |
| pix_field1 | output | 1 | Field-1 tag of the sample |
| ccir_err | output | 1 | Sticky malformed-code flag |

## Verification
The byte-count limit can close the active region in the same cycle that the final luma byte of the line emits its sample. The bench sends exactly 2*ACT_PIX active bytes and then extra bytes before the end code. It expects `pix_valid` high with the last Y while `hact` has already fallen, and no sample from the extra bytes. A second coincidence is the end code arriving while the region is still open. There, the XY byte must close the region without being taken as a sample.

// File: rtl/vid656_pkg.sv
package vid656_pkg;

  localparam logic [7:0] PRE_FF = 8'hFF;
  localparam logic [7:0] PRE_00 = 8'h00;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } trs_t;

  typedef enum logic [1:0] {
    PH_CB = 2'd0,
    PH_Y0 = 2'd1,
    PH_CR = 2'd2,
    PH_Y1 = 2'd3
  } phase_e;

  function automatic logic [3:0] prot_bits(input logic f, input logic v, input logic h);
    return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/vid656_trs.sv
module vid656_trs
  import vid656_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] byte_in,
  output logic       code_ok,
  output logic       code_bad,
  output logic       code_f,
  output logic       code_v,
  output logic       code_h
);

  logic [7:0] h0_q, h1_q, h2_q;
  logic       preamble;
  logic       prot_ok;
  trs_t       code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h0_q <= '0;
      h1_q <= '0;
      h2_q <= '0;
    end else begin
      h0_q <= byte_in;
      h1_q <= h0_q;
      h2_q <= h1_q;
    end
  end

  always_comb begin
    code     = '{f: byte_in[6], v: byte_in[5], h: byte_in[4]};
    preamble = (h2_q == PRE_FF) && (h1_q == PRE_00) && (h0_q == PRE_00);
    prot_ok  = byte_in[7] && (byte_in[3:0] == prot_bits(code.f, code.v, code.h));
    code_ok  = preamble && prot_ok;
    code_bad = preamble && !prot_ok;
    code_f   = code.f;
    code_v   = code.v;
    code_h   = code.h;
  end

endmodule

// File: rtl/vid656_line.sv
module vid656_line #(
  parameter int LW        = 10,
  parameter int LINES_625 = 288,
  parameter int LINES_525 = 243
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          code_ok,
  input  logic          code_v,
  input  logic          code_h,
  input  logic          mode_625,
  input  logic [LW-1:0] vstart,
  input  logic [LW-1:0] vend,
  output logic [LW-1:0] line_q,
  output logic          vwin_q
);

  localparam logic [LW-1:0] LAST_625 = LW'(LINES_625 - 1);
  localparam logic [LW-1:0] LAST_525 = LW'(LINES_525 - 1);
  localparam logic [LW-1:0] LINE_SAT = '1;

  logic [LW-1:0] last_line, eff_end, line_n;
  logic          vwin_n;

  always_comb begin
    last_line = mode_625 ? LAST_625 : LAST_525;
    eff_end   = (vend > last_line) ? last_line : vend;
    line_n    = line_q;
    vwin_n    = vwin_q;
    if (code_v) begin
      line_n = '0;
    end else if (code_h && (line_q != LINE_SAT)) begin
      line_n = line_q + 1'b1;
    end
    if (code_h || code_v) begin
      vwin_n = 1'b0;
    end else begin
      vwin_n = (line_q >= vstart) && (line_q <= eff_end);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      vwin_q <= 1'b0;
    end else if (code_ok) begin
      line_q <= line_n;
      vwin_q <= vwin_n;
    end
  end

endmodule

// File: rtl/vid656_demux.sv
module vid656_demux
  import vid656_pkg::*;
#(
  parameter int ACT_PIX = 720
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] byte_in,
  input  logic       code_ok,
  input  logic       code_v,
  input  logic       code_h,
  input  logic       win,
  output logic       act_q,
  output logic       emit,
  output logic       pv_q,
  output logic [7:0] y_o,
  output logic [7:0] cb_o,
  output logic [7:0] cr_o
);

  localparam int ABYTES = 2 * ACT_PIX;
  localparam int CW     = $clog2(ABYTES);
  localparam logic [CW-1:0] CNT_LAST = CW'(ABYTES - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          act_n;
  logic [7:0]    cb_q, cb_n, y0_q, y0_n, cr_q, cr_n;
  logic [7:0]    ey, ecr;
  phase_e        phase;

  always_comb begin
    act_n = act_q;
    cnt_n = cnt_q;
    cb_n  = cb_q;
    y0_n  = y0_q;
    cr_n  = cr_q;
    ey    = y0_q;
    ecr   = cr_q;
    emit  = 1'b0;
    phase = phase_e'(cnt_q[1:0]);
    if (code_ok) begin
      act_n = !code_h && !code_v;
      cnt_n = '0;
    end else if (act_q) begin
      cnt_n = cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) act_n = 1'b0;
      unique case (phase)
        PH_CB: cb_n = byte_in;
        PH_Y0: y0_n = byte_in;
        PH_CR: begin
          cr_n = byte_in;
          ecr  = byte_in;
          emit = 1'b1;
        end
        PH_Y1: begin
          ey   = byte_in;
          emit = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      cb_q  <= '0;
      y0_q  <= '0;
      cr_q  <= '0;
      pv_q  <= 1'b0;
    end else begin
      act_q <= act_n;
      cnt_q <= cnt_n;
      cb_q  <= cb_n;
      y0_q  <= y0_n;
      cr_q  <= cr_n;
      pv_q  <= emit && win;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_o  <= '0;
      cb_o <= '0;
      cr_o <= '0;
    end else if (emit) begin
      y_o  <= ey;
      cb_o <= cb_q;
      cr_o <= ecr;
    end
  end

endmodule

// File: rtl/vid656_tracker.sv
module vid656_tracker #(
  parameter int ACT_PIX   = 720,
  parameter int LINES_625 = 288,
  parameter int LINES_525 = 243,
  parameter int LW        = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    vid_byte,
  input  logic          mode_625,
  input  logic          master,
  input  logic          field_in,
  input  logic [LW-1:0] vwin_start,
  input  logic [LW-1:0] vwin_end,
  output logic          field_out,
  output logic          field_oe,
  output logic          hact,
  output logic          vact,
  output logic          pix_valid,
  output logic [7:0]    pix_y,
  output logic [7:0]    pix_cb,
  output logic [7:0]    pix_cr,
  output logic          pix_field1,
  output logic          ccir_err
);

  logic          code_ok, code_bad, code_f, code_v, code_h;
  logic [LW-1:0] line_q;
  logic          emit;
  logic          f1_q, f1_n, tag_q, tag_n, err_q, err_n;

  vid656_trs trs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_in  (vid_byte),
    .code_ok  (code_ok),
    .code_bad (code_bad),
    .code_f   (code_f),
    .code_v   (code_v),
    .code_h   (code_h)
  );

  vid656_line #(
    .LW        (LW),
    .LINES_625 (LINES_625),
    .LINES_525 (LINES_525)
  ) line_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .code_ok  (code_ok),
    .code_v   (code_v),
    .code_h   (code_h),
    .mode_625 (mode_625),
    .vstart   (vwin_start),
    .vend     (vwin_end),
    .line_q   (line_q),
    .vwin_q   (vact)
  );

  vid656_demux #(
    .ACT_PIX (ACT_PIX)
  ) demux_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .byte_in (vid_byte),
    .code_ok (code_ok),
    .code_v  (code_v),
    .code_h  (code_h),
    .win     (vact),
    .act_q   (hact),
    .emit    (emit),
    .pv_q    (pix_valid),
    .y_o     (pix_y),
    .cb_o    (pix_cb),
    .cr_o    (pix_cr)
  );

  always_comb begin
    f1_n  = code_ok ? !code_f : f1_q;
    tag_n = emit ? (master ? f1_q : field_in) : tag_q;
    err_n = err_q | code_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f1_q  <= 1'b0;
      tag_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      f1_q  <= f1_n;
      tag_q <= tag_n;
      err_q <= err_n;
    end
  end

  assign field_out  = master & f1_q;
  assign field_oe   = master;
  assign pix_field1 = tag_q;
  assign ccir_err   = err_q;

endmodule

// File: rtl/vid656_tracker_chk.sv
module vid656_tracker_chk #(
  parameter int LW        = 10,
  parameter int LINES_625 = 288,
  parameter int LINES_525 = 243
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_valid,
  input logic          vact,
  input logic          ccir_err,
  input logic          mode_625,
  input logic [LW-1:0] line_q
);

  assert_err_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ccir_err |=> ccir_err);

  assert_pix_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> vact);

  assert_win_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vact) |-> (line_q <= (mode_625 ? LW'(LINES_625 - 1) : LW'(LINES_525 - 1))));

  assert_pair_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && $past(pix_valid)) |=> !pix_valid);

endmodule

bind vid656_tracker vid656_tracker_chk #(
  .LW        (LW),
  .LINES_625 (LINES_625),
  .LINES_525 (LINES_525)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .pix_valid (pix_valid),
  .vact      (vact),
  .ccir_err  (ccir_err),
  .mode_625  (mode_625),
  .line_q    (line_q)
);

// File: tb/vid656_tracker_tb_top.sv
`timescale 1ns/1ps
module vid656_tracker_tb_top;

  localparam int APIX = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] vid_byte = 8'h10;
  logic       mode_625 = 1'b1;
  logic       master = 1'b1;
  logic       field_in = 1'b0;
  logic [9:0] vwin_start = '0;
  logic [9:0] vwin_end = 10'd1023;
  logic       field_out, field_oe, hact, vact, pix_valid, pix_field1, ccir_err;
  logic [7:0] pix_y, pix_cb, pix_cr;

  int checks = 0;
  int errors = 0;

  // Each entry: {Cb, Y0, Cr, Y1}
  localparam logic [31:0] QUADS [4] = '{
    32'h40_20_C0_30,
    32'h80_A0_10_EB,
    32'h01_FE_F0_11,
    32'h7F_80_81_55
  };

  always #5 clk = ~clk;

  vid656_tracker #(.ACT_PIX(APIX)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .vid_byte   (vid_byte),
    .mode_625   (mode_625),
    .master     (master),
    .field_in   (field_in),
    .vwin_start (vwin_start),
    .vwin_end   (vwin_end),
    .field_out  (field_out),
    .field_oe   (field_oe),
    .hact       (hact),
    .vact       (vact),
    .pix_valid  (pix_valid),
    .pix_y      (pix_y),
    .pix_cb     (pix_cb),
    .pix_cr     (pix_cr),
    .pix_field1 (pix_field1),
    .ccir_err   (ccir_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    vid_byte = b;
    @(posedge clk);
    #1;
  endtask

  task automatic code(input logic f, input logic v, input logic h, input logic good);
    logic [7:0] xy;
    xy = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    if (!good) xy[0] = ~xy[0];
    put(8'hFF);
    put(8'h00);
    put(8'h00);
    put(xy);
  endtask

  task automatic blank_line(input logic f);
    code(f, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 2 * APIX; i++) put(8'h10);
    code(f, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic pic_line(input logic f, output int npix, output int vseen);
    code(f, 1'b0, 1'b0, 1'b1);
    vseen = int'(vact);
    npix = 0;
    for (int i = 0; i < 2 * APIX; i++) begin
      put(8'h50 + 8'(i));
      npix += int'(pix_valid);
    end
    code(f, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int np, vs;
    logic [31:0] q;

    // R9: reset state
    do_reset();
    chk("R9 ccir_err", ccir_err, 0);
    chk("R9 pix_valid", pix_valid, 0);
    chk("R9 hact", hact, 0);
    chk("R9 vact", vact, 0);
    chk("R9 field_out", field_out, 0);

    // R7: master field indicator follows F of valid codes
    code(1'b1, 1'b1, 1'b0, 1'b1);
    chk("R7 field_oe", field_oe, 1);
    chk("R7 field_out F=1", field_out, 0);
    code(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R7 field_out F=0", field_out, 1);

    // R3: table of sample quads walked by one loop, two quads per line
    blank_line(1'b0);
    for (int k = 0; k < 4; k++) begin
      q = QUADS[k];
      if (k % 2 == 0) begin
        code(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R5 vact in window", vact, 1);
        chk("R4 hact opens", hact, 1);
      end
      put(q[31:24]);
      chk("R3 no sample after Cb", pix_valid, 0);
      put(q[23:16]);
      chk("R3 no sample after Y0", pix_valid, 0);
      put(q[15:8]);
      chk("R3 valid after Cr", pix_valid, 1);
      chk("R3 Y0", pix_y, q[23:16]);
      chk("R3 Cb", pix_cb, q[31:24]);
      chk("R3 Cr", pix_cr, q[15:8]);
      put(q[7:0]);
      chk("R3 valid after Y1", pix_valid, 1);
      chk("R3 Y1", pix_y, q[7:0]);
      chk("R3 Cb kept", pix_cb, q[31:24]);
      chk("R3 Cr kept", pix_cr, q[15:8]);
      if (k % 2 == 1) begin
        // R4: byte limit closes the region in the cycle of the last sample
        chk("R4 hact closes at limit", hact, 0);
        put(8'h66);
        chk("R4 no sample past limit", pix_valid, 0);
        put(8'h66);
        put(8'h66);
        chk("R4 still no sample", pix_valid, 0);
        chk("R4 Y unchanged", pix_y, q[7:0]);
        code(1'b0, 1'b0, 1'b1, 1'b1);
      end
    end

    // R10: start code in vertical blanking does not open active region
    code(1'b0, 1'b1, 1'b0, 1'b1);
    put(8'h40);
    chk("R10 hact stays low", hact, 0);
    code(1'b0, 1'b1, 1'b1, 1'b1);

    // R5: window 2..3
    vwin_start = 10'd2;
    vwin_end = 10'd3;
    blank_line(1'b0);
    for (int l = 0; l < 5; l++) begin
      pic_line(1'b0, np, vs);
      if (l == 1) begin chk("R5 line1 pix", np, 0); chk("R5 line1 vact", vs, 0); end
      if (l == 2) begin chk("R5 line2 pix", np, 4); chk("R5 line2 vact", vs, 1); end
      if (l == 3) chk("R5 line3 pix", np, 4);
      if (l == 4) begin chk("R5 line4 pix", np, 0); chk("R5 line4 vact", vs, 0); end
    end

    // R6: clamp in 243-line format
    mode_625 = 1'b0;
    vwin_start = 10'd240;
    vwin_end = 10'd1000;
    blank_line(1'b1);
    for (int l = 0; l < 244; l++) begin
      pic_line(1'b1, np, vs);
      if (l == 239) chk("R6 525 line239", np, 0);
      if (l == 240) chk("R6 525 line240", np, 4);
      if (l == 242) chk("R6 525 line242", np, 4);
      if (l == 243) chk("R6 525 line243 clamped", np, 0);
    end

    // R6: clamp in 288-line format
    mode_625 = 1'b1;
    vwin_start = 10'd286;
    vwin_end = 10'd600;
    blank_line(1'b0);
    for (int l = 0; l < 289; l++) begin
      pic_line(1'b0, np, vs);
      if (l == 285) chk("R6 625 line285", np, 0);
      if (l == 287) chk("R6 625 line287", np, 4);
      if (l == 288) chk("R6 625 line288 clamped", np, 0);
    end

    // R8: slave mode, sample tag follows field_in
    master = 1'b0;
    vwin_start = 10'd0;
    vwin_end = 10'd1023;
    blank_line(1'b0);
    chk("R8 field_oe", field_oe, 0);
    chk("R8 field_out", field_out, 0);
    field_in = 1'b1;
    pic_line(1'b0, np, vs);
    chk("R8 tag high", pix_field1, 1);
    field_in = 1'b0;
    pic_line(1'b1, np, vs);
    chk("R8 tag low", pix_field1, 0);
    master = 1'b1;

    // R2: bad protection bits set sticky flag and the code is ignored
    code(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R2 flag clear before", ccir_err, 0);
    chk("R2 field_out before", field_out, 1);
    code(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R2 flag set", ccir_err, 1);
    chk("R2 field_out unchanged", field_out, 1);
    put(8'h40);
    chk("R2 bad code opens nothing", hact, 0);
    blank_line(1'b0);
    pic_line(1'b0, np, vs);
    chk("R2 flag sticky", ccir_err, 1);

    // R1: bit 7 clear makes the code malformed
    do_reset();
    chk("R9 flag cleared by reset", ccir_err, 0);
    put(8'hFF);
    put(8'h00);
    put(8'h00);
    put(8'h00);
    chk("R1 bit7 clear flagged", ccir_err, 1);
    do_reset();
    code(1'b1, 1'b0, 1'b0, 1'b1);
    chk("R1 valid code no flag", ccir_err, 0);
    chk("R1 valid code opens region", hact, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule